// File: doc/BRIEF.md
# Sleep Mode Sequencer for a Synchronous Memory

This controller sits beside the array of a synchronous memory. It takes a low-power request that can change at any time relative to the clock and passes it through a flop synchronizer. It then moves the memory through a fixed sequence: awake, entering, asleep, exiting, recovery, and back to awake. The entry and exit phases each last a set number of clock cycles. While the sequence runs, new accesses are refused and the data bus is not driven. An access that has been granted but has not completed when the synchronized request arrives is dropped and never reports completion. The controller never writes to or clears the array, so stored contents survive the sleep period.

Once the exit phase ends, a recovery window holds selects off for a set number of cycles. A one-cycle protocol-error pulse reports two kinds of misuse: a select attempted during recovery, and a select presented in the cycle in which a synchronized sleep request is seen while awake.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset, sleepActive, lowPower, recovActive, accessGrant, accessDone, busOe and protoErr are all 0.
- R2: sleepReq is synchronized through SYNC_STAGES flops (default 2). When it rises while awake, sleepActive goes to 1 after the (SYNC_STAGES+1)-th rising clock edge that follows the change.
- R3: Entry lasts ENTRY_CYC cycles (default 2). lowPower goes to 1 exactly ENTRY_CYC cycles after sleepActive goes to 1, and the asleep state is reached only from the entry phase.
- R4: When sleepReq falls while asleep, lowPower goes to 0 after the (SYNC_STAGES+1)-th rising edge. sleepActive stays at 1 for EXIT_CYC further cycles (default 2), and then recovActive goes to 1 in the same cycle that sleepActive goes to 0.
- R5: recovActive stays at 1 for RECOV_CYC cycles (default 2). The block then returns to awake, with sleepActive and recovActive both 0.
- R6: accessGrant equals selReq only while the block is awake and the synchronized request is 0. It is 0 whenever sleepActive or recovActive is 1.
- R7: A grant produces accessDone in the next cycle. busOe is 1 only when accessDone is 1 and the granted access was a read (selWe = 0).
- R8: If the synchronized request becomes 1 in the cycle after a grant, that access is discarded: accessDone and busOe stay at 0.
- R9: protoErr is 1 for exactly one cycle after either of two events: selReq = 1 while recovActive = 1, or selReq = 1 while awake with the synchronized request at 1.
- R10: Entry and exit latencies are fixed. If the request drops during entry, lowPower still goes to 1, and then the exit sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Asynchronous low-power request |
| selReq | input | 1 | Access select attempt this cycle |
| selWe | input | 1 | 1 = write, 0 = read, for the attempted access |
| accessGrant | output | 1 | Select accepted this cycle |
| accessDone | output | 1 | Granted access completes this cycle |
| busOe | output | 1 | Data bus driven (read completion) |
| sleepActive | output | 1 | Entry, asleep or exit phase in progress |
| lowPower | output | 1 | Asleep state reached |
| recovActive | output | 1 | Post-wake recovery window |
| protoErr | output | 1 | One-cycle protocol violation pulse |

## Verification
The embedded assertions check the following on every cycle:
- No grant is issued while sleeping or recovering.
- Every completion has a grant one cycle earlier.
- No completion occurs during the sequence.
- The asleep state is entered only from the entry phase.
- Leaving recovery always lands in the awake state.

Some behaviours can only be shown by the bench's scenarios:
- The exact latencies counted from the asynchronous request.
- The dropping of the access caught at entry.
- The error pulses for misuse.
- A request withdrawn in the middle of entry.

For these, the bench runs directed sequences and also compares every output against a cycle model fed with random request and select patterns.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_ENTER  = 3'd1,
    ST_ASLEEP = 3'd2,
    ST_EXIT   = 3'd3,
    ST_RECOV  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEntry;
    logic loadExit;
    logic loadRecov;
    logic countDown;
  } seqStrobe_t;
endpackage

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       awake,
  output logic       sleepActive,
  output logic       lowPower,
  output logic       recovActive
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_AWAKE: if (reqSync) begin
        stateNext        = ST_ENTER;
        strobe.loadEntry = 1'b1;
      end
      ST_ENTER: if (cntZero) stateNext = ST_ASLEEP;
                else strobe.countDown = 1'b1;
      ST_ASLEEP: if (!reqSync) begin
        stateNext       = ST_EXIT;
        strobe.loadExit = 1'b1;
      end
      ST_EXIT: if (cntZero) begin
        stateNext        = ST_RECOV;
        strobe.loadRecov = 1'b1;
      end else strobe.countDown = 1'b1;
      ST_RECOV: if (cntZero) stateNext = ST_AWAKE;
                else strobe.countDown = 1'b1;
      default: stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= stateNext;
  end

  assign awake       = (state == ST_AWAKE);
  assign lowPower    = (state == ST_ASLEEP);
  assign recovActive = (state == ST_RECOV);
  assign sleepActive = (state == ST_ENTER) || (state == ST_ASLEEP) || (state == ST_EXIT);

  // R3
  asleep_from_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASLEEP && $past(state) != ST_ASLEEP) |-> $past(state) == ST_ENTER);

  // R5
  recov_to_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recovActive) |-> (state == ST_AWAKE));
endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       selReq,
  input  logic       selWe,
  input  seqStrobe_t strobe,
  input  logic       awake,
  input  logic       recovActive,
  output logic       reqSync,
  output logic       cntZero,
  output logic       accessGrant,
  output logic       accessDone,
  output logic       busOe,
  output logic       protoErr
);
  localparam int MAX_A = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int MAX_C = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;
  logic                   pendValid, pendWe;
  logic                   violation;

  // request synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sleepReq};
  end
  assign reqSync = syncQ[SYNC_STAGES-1];

  // phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.loadEntry) cnt <= CNT_W'(ENTRY_CYC - 1);
    else if (strobe.loadExit)  cnt <= CNT_W'(EXIT_CYC - 1);
    else if (strobe.loadRecov) cnt <= CNT_W'(RECOV_CYC - 1);
    else if (strobe.countDown) cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  // access gating and pending slot
  assign accessGrant = selReq && awake && !reqSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWe    <= 1'b0;
    end else begin
      pendValid <= accessGrant;
      pendWe    <= selWe;
    end
  end

  assign accessDone = pendValid && awake && !reqSync;
  assign busOe      = accessDone && !pendWe;

  // protocol error pulse
  assign violation = selReq && (recovActive || (awake && reqSync));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErr <= 1'b0;
    else       protoErr <= violation;
  end

  // R7
  done_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |-> $past(accessGrant));

  // R7
  oe_only_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> accessDone);
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic selReq,
  input  logic selWe,
  output logic accessGrant,
  output logic accessDone,
  output logic busOe,
  output logic sleepActive,
  output logic lowPower,
  output logic recovActive,
  output logic protoErr
);
  seqStrobe_t strobe;
  logic       reqSync, cntZero, awake;

  sleep_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqSync(reqSync), .cntZero(cntZero),
    .strobe(strobe), .awake(awake), .sleepActive(sleepActive),
    .lowPower(lowPower), .recovActive(recovActive)
  );

  sleep_seq_dp #(
    .SYNC_STAGES(SYNC_STAGES), .ENTRY_CYC(ENTRY_CYC),
    .EXIT_CYC(EXIT_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .selReq(selReq),
    .selWe(selWe), .strobe(strobe), .awake(awake),
    .recovActive(recovActive), .reqSync(reqSync), .cntZero(cntZero),
    .accessGrant(accessGrant), .accessDone(accessDone), .busOe(busOe),
    .protoErr(protoErr)
  );

  // R6
  no_grant_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessGrant |-> !sleepActive && !recovActive);

  // R8
  no_done_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |-> !sleepActive && !recovActive);
endmodule

// File: tb/test_sleep_seq_top.sv
module test_sleep_seq_top;
  localparam int SYNC = 2, ENT = 2, EXT = 2, REC = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic sleepReq = 1'b0, selReq = 1'b0, selWe = 1'b0;
  logic accessGrant, accessDone, busOe, sleepActive, lowPower, recovActive, protoErr;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  sleep_seq_top i_sleep_seq_top (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .selReq(selReq), .selWe(selWe),
    .accessGrant(accessGrant), .accessDone(accessDone), .busOe(busOe),
    .sleepActive(sleepActive), .lowPower(lowPower), .recovActive(recovActive),
    .protoErr(protoErr)
  );

  // ---- cycle model built from the requirements ----
  int   mSync;     // shift of synchronizer stages, bit SYNC-1 is the synced request
  int   mState;    // 0 awake,1 enter,2 asleep,3 exit,4 recov
  int   mCnt;
  logic mPend, mPendWe, mErr;

  function automatic logic mReqSync(); return mSync[SYNC-1]; endfunction
  function automatic logic expGrant(); return selReq && mState == 0 && !mReqSync(); endfunction
  function automatic logic expDone();  return mPend && mState == 0 && !mReqSync(); endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSync = 0; mState = 0; mCnt = 0; mPend = 0; mPendWe = 0; mErr = 0;
    end else begin
      logic rs;
      rs = mReqSync();
      mErr    = selReq && (mState == 4 || (mState == 0 && rs));
      mPend   = expGrant();
      mPendWe = selWe;
      case (mState)
        0: if (rs) begin mState = 1; mCnt = ENT; end
        1: begin mCnt--; if (mCnt == 0) mState = 2; end
        2: if (!rs) begin mState = 3; mCnt = EXT; end
        3: begin mCnt--; if (mCnt == 0) begin mState = 4; mCnt = REC; end end
        4: begin mCnt--; if (mCnt == 0) mState = 0; end
        default: mState = 0;
      endcase
      mSync = ((mSync << 1) | int'(sleepReq)) & ((1 << SYNC) - 1);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2", "sleepActive", sleepActive, mState inside {1, 2, 3});
    chk("R3", "lowPower", lowPower, mState == 2);
    chk("R5", "recovActive", recovActive, mState == 4);
    chk("R6", "accessGrant", accessGrant, expGrant());
    chk("R7", "accessDone", accessDone, expDone());
    chk("R7", "busOe", busOe, expDone() && !mPendWe);
    chk("R9", "protoErr", protoErr, mErr);
  endtask

  task automatic drive(input logic s, input logic sel, input logic we);
    sleepReq = s; selReq = sel; selWe = we;
  endtask

  // count negedges until sig matches val, at most lim
  task automatic waitFor(input int which, input logic val, output int k);
    logic v;
    k = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); k++;
      case (which)
        0: v = sleepActive; 1: v = lowPower; default: v = recovActive;
      endcase
      if (v === val) return;
    end
    k = -1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k, t0, seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sleepActive", sleepActive, 1'b0);
    chk("R1", "lowPower", lowPower, 1'b0);
    chk("R1", "recovActive", recovActive, 1'b0);
    chk("R1", "accessDone", accessDone, 1'b0);
    chk("R1", "busOe", busOe, 1'b0);
    chk("R1", "protoErr", protoErr, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 read grant completes next cycle with bus driven
    drive(0, 1, 0); #1;
    chk("R7", "grant", accessGrant, 1'b1);
    @(negedge clk); drive(0, 0, 0); #1;
    chk("R7", "done", accessDone, 1'b1);
    chk("R7", "busOe read", busOe, 1'b1);
    @(negedge clk);
    drive(0, 1, 1); @(negedge clk); drive(0, 0, 0); #1;
    chk("R7", "busOe write", busOe, 1'b0);
    @(negedge clk);

    // R2/R3 entry latencies
    drive(1, 0, 0);
    waitFor(0, 1'b1, k);
    chk("R2", "sleepActive latency ok", k == SYNC + 1, 1'b1);
    t0 = k;
    waitFor(1, 1'b1, k);
    chk("R3", "entry length ok", k == ENT, 1'b1);
    chk("R6", "no grant asleep", accessGrant, 1'b0);
    drive(1, 1, 0); #1;
    chk("R6", "grant blocked", accessGrant, 1'b0);
    drive(1, 0, 0);
    repeat (3) @(negedge clk);

    // R4/R5 exit and recovery
    drive(0, 0, 0);
    waitFor(1, 1'b0, k);
    chk("R4", "lowPower fall latency ok", k == SYNC + 1, 1'b1);
    waitFor(0, 1'b0, k);
    chk("R4", "exit length ok", k == EXT, 1'b1);
    chk("R4", "recov with exit end", recovActive, 1'b1);
    drive(0, 1, 0); #1;                 // select in recovery
    chk("R6", "grant in recovery", accessGrant, 1'b0);
    @(negedge clk); drive(0, 0, 0); #1;
    chk("R9", "err after recovery select", protoErr, 1'b1);
    @(negedge clk);
    chk("R9", "err one cycle", protoErr, 1'b0);
    chk("R5", "awake after recovery", recovActive || sleepActive, 1'b0);
    repeat (2) @(negedge clk);

    // R8 pending access discarded at entry
    drive(1, 0, 0); @(negedge clk);
    drive(1, 1, 0); #1;
    chk("R8", "grant before sync", accessGrant, 1'b1);
    @(negedge clk); drive(1, 0, 0); #1;
    chk("R8", "discarded done", accessDone, 1'b0);
    chk("R8", "discarded busOe", busOe, 1'b0);
    // R10 drop request during entry: entry still completes
    @(negedge clk); drive(0, 0, 0);
    waitFor(1, 1'b1, k);
    chk("R10", "lowPower despite drop", k > 0, 1'b1);
    waitFor(2, 1'b1, k); waitFor(2, 1'b0, k);
    @(negedge clk);

    // R9 select with synced request while awake
    drive(1, 0, 0); repeat (2) @(negedge clk);
    drive(1, 1, 0); @(negedge clk); drive(1, 0, 0); #1;
    chk("R9", "err select at entry", protoErr, 1'b1);
    drive(0, 0, 0);
    repeat (12) @(negedge clk);

    // random phase compared against the model
    begin
      int hold = 0;
      logic s = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        compareAll();
        if (hold == 0) begin s = ~s; hold = 1 + ($urandom % 20); end
        else hold--;
        drive(s, ($urandom % 3) == 0, $urandom % 2);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule